// File: doc/BRIEF.md
# Serial Command Sequencer and Register Bank

This block sits behind a byte-oriented serial control port. Each completed select-low window delivers one byte on a single-cycle strobe. When the block is idle, it decodes that byte as a command. A command is one of three kinds: a single-byte action, a register write that takes the next N strobed bytes as data, or a register read that returns N bytes on the output, one byte per window. An opcode that is not listed is dropped, and the byte after it is decoded as a fresh command.

The block holds four one-byte control registers and a small coefficient array. It also keeps the operating state (standby or active) and an interrupt flag, which gated event inputs set. A revision byte and a real-time status byte can be read. One form of the status read clears the interrupt flag. In each register pair, the even opcode writes and the next odd opcode reads the value back.

Top module: `slc_cmd_seq`

## Requirements
- R1: Opcode pairs 40h/41h (transmit slot), 42h/43h (receive slot), 46h/47h (configuration) and 6Ch/6Dh (interrupt mask) each hold one byte. The even code writes the next strobed byte, and the odd code reads it back. Each register also drives its own output port.
- R2: While a write is in progress, every strobed byte counts as data, even if it matches a command opcode, until the write's byte count is used up.
- R3: After a read opcode, `rd_busy` is high and `dout` holds the next byte to send. `dout` is valid after the accepting edge, and each strobe then consumes one byte. Bytes received during a read are ignored and change no state. No command is accepted before the last byte has been consumed.
- R4: Opcode 80h writes, and 81h reads, NCOEF coefficient bytes in index order starting at index 0.
- R5: Opcode 0Eh sets `active` to 1, 00h clears it to 0, and 06h changes nothing.
- R6: Opcode 02h resets the registers to their defaults (slots 0, configuration 0, mask MASK_DEF) and clears `active`. The coefficient array and the interrupt flag keep their values. Opcode 04h does the same and also clears the interrupt flag.
- R7: The interrupt flag is set in the cycle after any `irq_evt` bit whose mask bit is 0 is high. Opcode 4Dh reads one byte: the flag in bit 0 and `status_in` in bits 7:1. Opcode 4Fh reads the same byte and clears the flag at the accepting edge.
- R8: Opcode 73h reads the REV_CODE parameter. Opcode 72h and every other unlisted opcode are ignored: no state changes and no read starts.
- R9: After reset, `active`, `rd_busy` and `irq_flag` are 0, the slots and configuration are 0, and the mask equals MASK_DEF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_stb | input | 1 | One-cycle pulse per completed select-low window |
| byte_in | input | 8 | Byte received in that window |
| status_in | input | 7 | Live status bits reported by the real-time read |
| irq_evt | input | 8 | Interrupt event bits, each gated by its mask bit |
| dout | output | 8 | Next byte to shift out during a read |
| rd_busy | output | 1 | Read bytes still pending, commands locked out |
| active | output | 1 | Operating state, 1 = active, 0 = standby |
| irq_flag | output | 1 | Pending interrupt flag |
| tx_slot | output | 8 | Transmit slot register |
| rx_slot | output | 8 | Receive slot register |
| cfg | output | 8 | Configuration register |
| irq_mask | output | 8 | Interrupt mask register, 1 = masked |

## Verification
The bench builds the block with NCOEF = 3 and REV_CODE = 5Ah, and keeps MASK_DEF = FFh. With three coefficients, a multi-byte read can use an opcode-valued filler byte in every window, including the last data byte. The odd count also exercises a counter that does not end on a power of two. The revision value differs from every value the bench writes, so a read that decoded the wrong register would not match by chance.

// File: rtl/slc_cmd_pkg.sv
package slc_cmd_pkg;
  typedef enum logic [1:0] {K_NONE, K_ACT, K_WR, K_RD} cmd_kind_e;
  typedef enum logic [2:0] {S_TXS, S_RXS, S_CFG, S_MASK, S_COEF, S_RT, S_REV} reg_sel_e;
  typedef enum logic [1:0] {PH_IDLE, PH_WR, PH_RD} phase_e;

  localparam logic [7:0] OP_STBY = 8'h00;
  localparam logic [7:0] OP_SRST = 8'h02;
  localparam logic [7:0] OP_HRST = 8'h04;
  localparam logic [7:0] OP_NOP  = 8'h06;
  localparam logic [7:0] OP_ACT  = 8'h0E;
  localparam logic [7:0] OP_TXS  = 8'h40;
  localparam logic [7:0] OP_RXS  = 8'h42;
  localparam logic [7:0] OP_CFG  = 8'h46;
  localparam logic [7:0] OP_MASK = 8'h6C;
  localparam logic [7:0] OP_COEF = 8'h80;
  localparam logic [7:0] OP_RT   = 8'h4D;
  localparam logic [7:0] OP_RTC  = 8'h4F;
  localparam logic [7:0] OP_REV  = 8'h73;
endpackage

// File: rtl/slc_cmd_decode.sv
module slc_cmd_decode
  import slc_cmd_pkg::*;
#(
  parameter int NCOEF = 4,
  parameter int CW    = 3
) (
  input  logic [7:0]    op,
  output cmd_kind_e     kind,
  output reg_sel_e      sel,
  output logic [CW-1:0] len
);
  logic [7:0] pair;
  logic       is_rd;

  assign pair  = {op[7:1], 1'b0};
  assign is_rd = op[0];

  always_comb begin
    kind = K_NONE;
    sel  = S_TXS;
    len  = CW'(1);
    case (op)
      OP_STBY, OP_SRST, OP_HRST, OP_NOP, OP_ACT: kind = K_ACT;
      OP_RT, OP_RTC: begin kind = K_RD; sel = S_RT;  end
      OP_REV:        begin kind = K_RD; sel = S_REV; end
      default: begin
        case (pair)
          OP_TXS:  begin kind = is_rd ? K_RD : K_WR; sel = S_TXS;  end
          OP_RXS:  begin kind = is_rd ? K_RD : K_WR; sel = S_RXS;  end
          OP_CFG:  begin kind = is_rd ? K_RD : K_WR; sel = S_CFG;  end
          OP_MASK: begin kind = is_rd ? K_RD : K_WR; sel = S_MASK; end
          OP_COEF: begin
            kind = is_rd ? K_RD : K_WR;
            sel  = S_COEF;
            len  = CW'(NCOEF);
          end
          default: kind = K_NONE;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/slc_reg_bank.sv
module slc_reg_bank
  import slc_cmd_pkg::*;
#(
  parameter int          NCOEF    = 4,
  parameter int          IW       = 2,
  parameter logic [7:0]  REV_CODE = 8'h21,
  parameter logic [7:0]  MASK_DEF = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          we,
  input  reg_sel_e      wsel,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic          rd_en,
  input  reg_sel_e      rsel,
  input  logic [IW-1:0] ridx,
  input  logic [7:0]    rt_byte,
  output logic [7:0]    txs_q,
  output logic [7:0]    rxs_q,
  output logic [7:0]    cfg_q,
  output logic [7:0]    mask_q,
  output logic [7:0]    rd_q
);
  logic [7:0] coef_mem [NCOEF];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      txs_q  <= 8'h00;
      rxs_q  <= 8'h00;
      cfg_q  <= 8'h00;
      mask_q <= MASK_DEF;
    end else if (we) begin
      case (wsel)
        S_TXS:   txs_q  <= wdata;
        S_RXS:   rxs_q  <= wdata;
        S_CFG:   cfg_q  <= wdata;
        S_MASK:  mask_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (we && wsel == S_COEF) coef_mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 8'h00;
    end else if (rd_en) begin
      case (rsel)
        S_TXS:   rd_q <= txs_q;
        S_RXS:   rd_q <= rxs_q;
        S_CFG:   rd_q <= cfg_q;
        S_MASK:  rd_q <= mask_q;
        S_COEF:  rd_q <= coef_mem[ridx];
        S_RT:    rd_q <= rt_byte;
        S_REV:   rd_q <= REV_CODE;
        default: rd_q <= 8'h00;
      endcase
    end
  end

  assert_soft_rst_R6: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (txs_q == 8'h00 && rxs_q == 8'h00 && cfg_q == 8'h00 && mask_q == MASK_DEF));

  assert_rev_read_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rsel == S_REV) |=> rd_q == REV_CODE);
endmodule

// File: rtl/slc_cmd_seq.sv
module slc_cmd_seq
  import slc_cmd_pkg::*;
#(
  parameter int         NCOEF    = 4,
  parameter logic [7:0] REV_CODE = 8'h21,
  parameter logic [7:0] MASK_DEF = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_stb,
  input  logic [7:0] byte_in,
  input  logic [6:0] status_in,
  input  logic [7:0] irq_evt,
  output logic [7:0] dout,
  output logic       rd_busy,
  output logic       active,
  output logic       irq_flag,
  output logic [7:0] tx_slot,
  output logic [7:0] rx_slot,
  output logic [7:0] cfg,
  output logic [7:0] irq_mask
);
  localparam int CW = $clog2(NCOEF + 1);
  localparam int IW = (NCOEF > 1) ? $clog2(NCOEF) : 1;

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  reg_sel_e      cur_sel;

  cmd_kind_e     dec_kind;
  reg_sel_e      dec_sel;
  logic [CW-1:0] dec_len;

  logic          accept, last, soft_rst, irq_hit, irq_clr;
  logic          we, rd_en;
  reg_sel_e      rsel;
  logic [IW-1:0] ridx;
  logic [7:0]    rt_byte;

  slc_cmd_decode #(.NCOEF(NCOEF), .CW(CW)) u_dec (
    .op   (byte_in),
    .kind (dec_kind),
    .sel  (dec_sel),
    .len  (dec_len)
  );

  assign accept   = byte_stb && phase == PH_IDLE;
  assign last     = cnt == CW'(1);
  assign soft_rst = accept && (byte_in == OP_SRST || byte_in == OP_HRST);
  assign irq_hit  = |(irq_evt & ~irq_mask);
  assign irq_clr  = accept && (byte_in == OP_RTC || byte_in == OP_HRST);
  assign rt_byte  = {status_in, irq_flag};

  assign we    = byte_stb && phase == PH_WR;
  assign rd_en = (accept && dec_kind == K_RD) || (byte_stb && phase == PH_RD && !last);
  assign rsel  = (phase == PH_IDLE) ? dec_sel : cur_sel;
  assign ridx  = (phase == PH_IDLE) ? '0 : idx + IW'(1);

  slc_reg_bank #(
    .NCOEF(NCOEF), .IW(IW), .REV_CODE(REV_CODE), .MASK_DEF(MASK_DEF)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .we       (we),
    .wsel     (cur_sel),
    .widx     (idx),
    .wdata    (byte_in),
    .rd_en    (rd_en),
    .rsel     (rsel),
    .ridx     (ridx),
    .rt_byte  (rt_byte),
    .txs_q    (tx_slot),
    .rxs_q    (rx_slot),
    .cfg_q    (cfg),
    .mask_q   (irq_mask),
    .rd_q     (dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      idx     <= '0;
      cur_sel <= S_TXS;
    end else if (byte_stb) begin
      if (phase == PH_IDLE) begin
        if (dec_kind == K_WR || dec_kind == K_RD) begin
          phase   <= (dec_kind == K_WR) ? PH_WR : PH_RD;
          cnt     <= dec_len;
          idx     <= '0;
          cur_sel <= dec_sel;
        end
      end else begin
        cnt <= cnt - CW'(1);
        idx <= idx + IW'(1);
        if (last) phase <= PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
    end else if (accept) begin
      case (byte_in)
        OP_STBY, OP_SRST, OP_HRST: active <= 1'b0;
        OP_ACT:                    active <= 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          irq_flag <= 1'b0;
    else if (irq_hit) irq_flag <= 1'b1;
    else if (irq_clr) irq_flag <= 1'b0;
  end

  assign rd_busy = phase == PH_RD;

  assert_wr_data_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WR && byte_stb && !last) |=> phase == PH_WR);

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RD && !byte_stb) |=> (phase == PH_RD && $stable(dout)));

  assert_rd_lock_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RD && byte_stb) |=> ($stable(active) && $stable(cfg) && $stable(tx_slot)));

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && byte_in == OP_RTC && !irq_hit) |=> !irq_flag);

  assert_reserved_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && dec_kind == K_NONE) |=>
      (phase == PH_IDLE && $stable(active) && $stable(cfg) && $stable(irq_mask)));
endmodule

// File: tb/slc_cmd_seq_tb.sv
module slc_cmd_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_stb = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [6:0] status_in = 7'h2B;
  logic [7:0] irq_evt = 8'h00;
  logic [7:0] dout, tx_slot, rx_slot, cfg, irq_mask;
  logic       rd_busy, active, irq_flag;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slc_cmd_seq #(.NCOEF(3), .REV_CODE(8'h5A), .MASK_DEF(8'hFF)) u_dut (
    .clk(clk), .rst(rst), .byte_stb(byte_stb), .byte_in(byte_in),
    .status_in(status_in), .irq_evt(irq_evt), .dout(dout), .rd_busy(rd_busy),
    .active(active), .irq_flag(irq_flag), .tx_slot(tx_slot), .rx_slot(rx_slot),
    .cfg(cfg), .irq_mask(irq_mask)
  );

  // {write opcode, data, expected readback}
  localparam logic [23:0] VEC [6] = '{
    24'h40_12_12, 24'h42_34_34, 24'h46_56_56,
    24'h6C_0F_0F, 24'h40_A5_A5, 24'h42_00_00
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); byte_stb = 1'b1; byte_in = b;
    @(negedge clk); byte_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic evt(input logic [7:0] e);
    @(negedge clk); irq_evt = e;
    @(negedge clk); irq_evt = 8'h00;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 active", {7'd0, active}, 8'h00);
    chk("R9 rd_busy", {7'd0, rd_busy}, 8'h00);
    chk("R9 irq_flag", {7'd0, irq_flag}, 8'h00);
    chk("R9 tx_slot", tx_slot, 8'h00);
    chk("R9 cfg", cfg, 8'h00);
    chk("R9 mask", irq_mask, 8'hFF);

    // R1: table of write/readback pairs; filler 00h during read must be ignored (R3)
    foreach (VEC[i]) begin
      put(VEC[i][23:16]);
      put(VEC[i][15:8]);
      put(VEC[i][23:16] | 8'h01);
      chk("R3 busy during read", {7'd0, rd_busy}, 8'h01);
      chk("R1 readback", dout, VEC[i][7:0]);
      put(8'h00);
      chk("R3 busy after read", {7'd0, rd_busy}, 8'h00);
    end
    chk("R1 tx_slot port", tx_slot, 8'hA5);
    chk("R1 rx_slot port", rx_slot, 8'h00);
    chk("R1 cfg port", cfg, 8'h56);
    chk("R1 mask port", irq_mask, 8'h0F);

    // R2: an opcode-valued data byte is stored, not executed
    put(8'h40); put(8'h0E);
    chk("R2 data stored", tx_slot, 8'h0E);
    chk("R2 not executed", {7'd0, active}, 8'h00);

    // R4: coefficient block write/read
    put(8'h80); put(8'h11); put(8'h22); put(8'h0E);
    chk("R2 coef last byte not executed", {7'd0, active}, 8'h00);
    put(8'h81);
    chk("R4 coef0", dout, 8'h11);
    put(8'h0E);
    chk("R3 filler ignored", {7'd0, active}, 8'h00);
    chk("R4 coef1", dout, 8'h22);
    put(8'h0E);
    chk("R4 coef2", dout, 8'h0E);
    chk("R3 still busy", {7'd0, rd_busy}, 8'h01);
    put(8'h0E);
    chk("R3 read done", {7'd0, rd_busy}, 8'h00);
    chk("R3 last filler ignored", {7'd0, active}, 8'h00);

    // R5: single-byte actions
    put(8'h0E); chk("R5 activate", {7'd0, active}, 8'h01);
    put(8'h06); chk("R5 no-op", {7'd0, active}, 8'h01);
    put(8'h00); chk("R5 standby", {7'd0, active}, 8'h00);

    // R8: reserved opcodes ignored, following byte decoded as a command
    put(8'h72);
    chk("R8 72h no read", {7'd0, rd_busy}, 8'h00);
    chk("R8 72h no state", tx_slot, 8'h0E);
    put(8'h73);
    chk("R8 revision", dout, 8'h5A);
    put(8'h00);
    put(8'h48);
    chk("R8 48h no read", {7'd0, rd_busy}, 8'h00);
    chk("R8 48h cfg kept", cfg, 8'h56);

    // R7: interrupt gating and status reads (mask is 0Fh, status 2Bh)
    evt(8'h01);
    chk("R7 masked event", {7'd0, irq_flag}, 8'h00);
    evt(8'h10);
    chk("R7 unmasked event", {7'd0, irq_flag}, 8'h01);
    put(8'h4D);
    chk("R7 status read", dout, 8'h57);
    put(8'h00);
    chk("R7 4Dh keeps flag", {7'd0, irq_flag}, 8'h01);
    put(8'h4F);
    chk("R7 4Fh clears flag", {7'd0, irq_flag}, 8'h00);
    chk("R7 4Fh value", dout, 8'h57);
    put(8'h00);
    put(8'h4D);
    chk("R7 status after clear", dout, 8'h56);
    put(8'h00);

    // R6: software and hardware reset commands
    put(8'h0E);
    evt(8'h10);
    put(8'h02);
    chk("R6 soft active", {7'd0, active}, 8'h00);
    chk("R6 soft cfg", cfg, 8'h00);
    chk("R6 soft tx", tx_slot, 8'h00);
    chk("R6 soft mask", irq_mask, 8'hFF);
    chk("R6 soft keeps irq", {7'd0, irq_flag}, 8'h01);
    put(8'h81);
    chk("R6 coef kept", dout, 8'h11);
    put(8'h00); put(8'h00); put(8'h00);
    put(8'h04);
    chk("R6 hard clears irq", {7'd0, irq_flag}, 8'h00);
    chk("R6 hard idle", {7'd0, rd_busy}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule